// File: doc/BRIEF.md
# Interleaved-Memory Vector Adder

This block adds two vectors element by element and stores the sum vector back into the same on-block memory. A caller loads operands through a word-wide host port while the engine is idle. It then pulses `start` with three base addresses and an element count. The engine streams the two operand reads and the result write for every element through a memory split into independent modules. Sums come out of a four-stage adder.

A module serves one access at a time, and each access keeps it occupied for two cycles. A per-cycle arbiter grants the three streams in the order operand A, operand B, result C, and holds back any stream whose module is occupied or already claimed. A stalled read leaves a bubble at the adder input. A stalled write leaves its sum waiting in a small result buffer. An in-flight credit limit stops new reads before that buffer can overflow. When the layout puts the three streams in different modules, one element finishes every cycle. A cycle counter shows the elapsed time of each run.

Top module: `vadd_bank_engine`

## Requirements
- R1: After a run, word `(baseC+i) mod 256` holds `(A[(baseA+i) mod 256] + B[(baseB+i) mod 256]) mod 2^16` for every i from 0 to len-1. No other word changes.
- R2: `start` is sampled only while `busy` is low. A `start` pulse while `busy` is high has no effect on memory or timing.
- R3: `busy` rises in the cycle after an accepted `start` with nonzero len. It stays high until the last result write has retired. `done` is then high for exactly one cycle, with `busy` low.
- R4: When `baseA mod 8`, `baseB mod 8` and `(baseC-7) mod 8` differ pairwise by 2 to 6 (mod 8), the run produces one element per cycle. `cycles` then reads len+8 when `done` is high: the ideal 4+len-1 plus 5 cycles of memory, buffer and write-retire latency.
- R5: The module of an address is its low 3 bits (8 modules). In any cycle, at most one stream accesses a module, and a module accessed in one cycle is not accessed in the next. On contention, A wins over B and B wins over C.
- R6: Layouts whose streams collide on modules still give the R1 result, but take more than len+8 cycles.
- R7: `start` with len 0 touches no memory, keeps `busy` low, and raises `done` in the next cycle with `cycles` at 0.
- R8: While idle, a host write stores `hostWdata` at `hostAddr`. A host read returns the word on `hostRdata` in the following cycle. Host accesses while `busy` is high are ignored.
- R9: After reset, `busy` and `done` are low and `cycles` is 0.
- R10: The result buffer never holds more than its depth (8), and a write is never issued from an empty buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, sampled while idle |
| baseA | input | 8 | First word of operand A |
| baseB | input | 8 | First word of operand B |
| baseC | input | 8 | First word of the result |
| len | input | 9 | Element count (0 to 256) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 16 | Busy cycles of the latest run |
| hostEn | input | 1 | Host access strobe (idle only) |
| hostWe | input | 1 | Host access is a write |
| hostAddr | input | 8 | Host word address |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data, one cycle after the request |

## Verification
The checker watches the arbiter's grants on every clock. No module is granted to two streams at once, and none is granted twice in a row. The result buffer stays within its depth and is never drained when empty. The checker also enforces the shape of the `done` pulse and the len 0 response. Three things show only in the bench's runs: the exact len+8 cycle count for well-spread layouts, the slowdown and unchanged results for colliding layouts, and the dropping of requests made mid-run. The bench reads the whole memory back after each run and compares it with its own model.

// File: rtl/vadd_pkg.sv
package vadd_pkg;
  parameter int DATA_W = 16;
  parameter int ADDR_W = 8;
  localparam int LEN_W = ADDR_W + 1;

  // Strobes from the sequencer to the datapath for one cycle.
  typedef struct packed {
    logic              idle;
    logic              rdA;
    logic              rdB;
    logic              wrC;
    logic [ADDR_W-1:0] addrA;
    logic [ADDR_W-1:0] addrB;
    logic [ADDR_W-1:0] addrC;
  } vaStrobe_t;
endpackage

// File: rtl/vadd_ctrl.sv
module vadd_ctrl
  import vadd_pkg::*;
#(
  parameter int BANKS      = 8,
  parameter int RBUF_DEPTH = 8,
  parameter int CYC_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseA,
  input  logic [ADDR_W-1:0] baseB,
  input  logic [ADDR_W-1:0] baseC,
  input  logic [LEN_W-1:0]  len,
  input  logic              fifoHasData,
  output logic              busy,
  output logic              done,
  output logic [CYC_W-1:0]  cycles,
  output vaStrobe_t         st
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int CNT_W  = $clog2(RBUF_DEPTH + 1);

  logic              running, ret1, doneQ, aIssued;
  logic [ADDR_W-1:0] bA, bB, bC;
  logic [LEN_W-1:0]  n, rdIdx, wrIdx;
  logic [CNT_W-1:0]  inflight;
  logic [BANKS-1:0]  busyBank, useNow;
  logic [ADDR_W-1:0] addrA, addrB, addrC;
  logic [BANK_W-1:0] bankA, bankB, bankC;
  logic              rdLive, gA, gB, gC, lastWr;

  assign addrA = bA + rdIdx[ADDR_W-1:0];
  assign addrB = bB + rdIdx[ADDR_W-1:0];
  assign addrC = bC + wrIdx[ADDR_W-1:0];
  assign bankA = addrA[BANK_W-1:0];
  assign bankB = addrB[BANK_W-1:0];
  assign bankC = addrC[BANK_W-1:0];

  // Fixed-priority arbitration: A, then B, then C.
  assign rdLive = running && (rdIdx < n);
  assign gA = rdLive && !aIssued && (inflight < CNT_W'(RBUF_DEPTH)) && !busyBank[bankA];
  assign gB = rdLive && (aIssued || gA) && !busyBank[bankB] && !(gA && bankA == bankB);
  assign gC = running && fifoHasData && !busyBank[bankC]
              && !(gA && bankA == bankC) && !(gB && bankB == bankC);
  assign lastWr = gC && (wrIdx == n - LEN_W'(1));

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      useNow[b] = (gA && bankA == BANK_W'(b)) || (gB && bankB == BANK_W'(b))
                  || (gC && bankC == BANK_W'(b));
    end
  end

  assign busy = running || ret1;
  assign done = doneQ;

  always_comb begin
    st.idle  = !busy;
    st.rdA   = gA;
    st.rdB   = gB;
    st.wrC   = gC;
    st.addrA = addrA;
    st.addrB = addrB;
    st.addrC = addrC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      ret1     <= 1'b0;
      doneQ    <= 1'b0;
      aIssued  <= 1'b0;
      inflight <= '0;
      busyBank <= '0;
      cycles   <= '0;
      rdIdx    <= '0;
      wrIdx    <= '0;
      n        <= '0;
      bA       <= '0;
      bB       <= '0;
      bC       <= '0;
    end else begin
      busyBank <= useNow;
      ret1     <= lastWr;
      doneQ    <= ret1 || (start && !busy && len == '0);
      if (start && !busy) begin
        cycles <= '0;
        if (len != '0) begin
          running  <= 1'b1;
          bA       <= baseA;
          bB       <= baseB;
          bC       <= baseC;
          n        <= len;
          rdIdx    <= '0;
          wrIdx    <= '0;
          aIssued  <= 1'b0;
          inflight <= '0;
        end
      end else begin
        if (busy) cycles <= cycles + CYC_W'(1);
        if (running) begin
          rdIdx <= rdIdx + LEN_W'(gB);
          wrIdx <= wrIdx + LEN_W'(gC);
          if (gB)      aIssued <= 1'b0;
          else if (gA) aIssued <= 1'b1;
          case ({gB, gC})
            2'b10:   inflight <= inflight + CNT_W'(1);
            2'b01:   inflight <= inflight - CNT_W'(1);
            default: inflight <= inflight;
          endcase
          if (lastWr) running <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/vadd_dpath.sv
module vadd_dpath
  import vadd_pkg::*;
#(
  parameter int BANKS      = 8,
  parameter int RBUF_DEPTH = 8,
  parameter int ADD_STAGES = 4,
  localparam int CNT_W     = $clog2(RBUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vaStrobe_t         st,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              fifoHasData,
  output logic [CNT_W-1:0]  fifoLevel
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int PTR_W  = $clog2(RBUF_DEPTH);

  logic                    hostWr, hostRd;
  logic                    aV1, bV1, aV2, bV2;
  logic [ADDR_W-1:0]       aAddr1, bAddr1;
  logic [BANK_W-1:0]       aBank2, bBank2, hostBank1;
  logic [BANKS*DATA_W-1:0] bankOut;
  logic [DATA_W-1:0]       aCur, bCur, aHold, opA, fifoHead;
  logic [DATA_W-1:0]       sumQ [ADD_STAGES];
  logic [ADD_STAGES-1:0]   vQ;
  logic [DATA_W-1:0]       fifoMem [RBUF_DEPTH];
  logic [PTR_W-1:0]        wrPtr, rdPtr;
  logic                    push, pop;

  assign hostWr = hostEn && hostWe && st.idle;
  assign hostRd = hostEn && !hostWe && st.idle;

  // One storage module per bank, each with a registered read port.
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] cells [ROWS];
    logic [DATA_W-1:0] q;
    logic [ROW_W-1:0]  rdRow;
    logic              weC, weH;
    assign weC = st.wrC && st.addrC[BANK_W-1:0] == BANK_W'(b);
    assign weH = hostWr && hostAddr[BANK_W-1:0] == BANK_W'(b);
    always_comb begin
      if (aV1 && aAddr1[BANK_W-1:0] == BANK_W'(b))      rdRow = aAddr1[ADDR_W-1:BANK_W];
      else if (bV1 && bAddr1[BANK_W-1:0] == BANK_W'(b)) rdRow = bAddr1[ADDR_W-1:BANK_W];
      else                                              rdRow = hostAddr[ADDR_W-1:BANK_W];
    end
    always_ff @(posedge clk) begin
      if (weC)      cells[st.addrC[ADDR_W-1:BANK_W]] <= fifoHead;
      else if (weH) cells[hostAddr[ADDR_W-1:BANK_W]] <= hostWdata;
      q <= cells[rdRow];
    end
    assign bankOut[b*DATA_W +: DATA_W] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aV1 <= 1'b0; bV1 <= 1'b0; aV2 <= 1'b0; bV2 <= 1'b0;
      vQ  <= '0;
    end else begin
      aV1 <= st.rdA;
      bV1 <= st.rdB;
      aV2 <= aV1;
      bV2 <= bV1;
      vQ  <= {vQ[ADD_STAGES-2:0], bV2};
    end
  end

  always_ff @(posedge clk) begin
    aAddr1 <= st.addrA;
    bAddr1 <= st.addrB;
    aBank2 <= aAddr1[BANK_W-1:0];
    bBank2 <= bAddr1[BANK_W-1:0];
    if (hostRd) hostBank1 <= hostAddr[BANK_W-1:0];
    if (aV2) aHold <= aCur;
    sumQ[0] <= opA + bCur;
    for (int k = 1; k < ADD_STAGES; k++) sumQ[k] <= sumQ[k-1];
  end

  assign aCur      = bankOut[aBank2*DATA_W +: DATA_W];
  assign bCur      = bankOut[bBank2*DATA_W +: DATA_W];
  assign opA       = aV2 ? aCur : aHold;
  assign hostRdata = bankOut[hostBank1*DATA_W +: DATA_W];

  // Result buffer between adder output and write stream.
  assign push        = vQ[ADD_STAGES-1];
  assign pop         = st.wrC;
  assign fifoHead    = fifoMem[rdPtr];
  assign fifoHasData = fifoLevel != '0;

  always_ff @(posedge clk) begin
    if (push) fifoMem[wrPtr] <= sumQ[ADD_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; fifoLevel <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(RBUF_DEPTH-1)) ? '0 : wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= (rdPtr == PTR_W'(RBUF_DEPTH-1)) ? '0 : rdPtr + PTR_W'(1);
      fifoLevel <= fifoLevel + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/vadd_bank_engine.sv
module vadd_bank_engine
  import vadd_pkg::*;
#(
  parameter int BANKS      = 8,
  parameter int RBUF_DEPTH = 8,
  parameter int ADD_STAGES = 4,
  parameter int CYC_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseA,
  input  logic [ADDR_W-1:0] baseB,
  input  logic [ADDR_W-1:0] baseC,
  input  logic [LEN_W-1:0]  len,
  output logic              busy,
  output logic              done,
  output logic [CYC_W-1:0]  cycles,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata
);
  localparam int CNT_W = $clog2(RBUF_DEPTH + 1);

  vaStrobe_t        strobe;
  logic             fifoHasData;
  logic [CNT_W-1:0] fifoLevel;

  vadd_ctrl #(.BANKS(BANKS), .RBUF_DEPTH(RBUF_DEPTH), .CYC_W(CYC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .baseA(baseA), .baseB(baseB),
    .baseC(baseC), .len(len), .fifoHasData(fifoHasData), .busy(busy),
    .done(done), .cycles(cycles), .st(strobe)
  );

  vadd_dpath #(.BANKS(BANKS), .RBUF_DEPTH(RBUF_DEPTH), .ADD_STAGES(ADD_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .st(strobe), .hostEn(hostEn), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .fifoHasData(fifoHasData), .fifoLevel(fifoLevel)
  );
endmodule

// File: rtl/vadd_chk.sv
module vadd_chk
  import vadd_pkg::*;
#(
  parameter int BANKS      = 8,
  parameter int RBUF_DEPTH = 8,
  localparam int CNT_W     = $clog2(RBUF_DEPTH + 1),
  localparam int BANK_W    = $clog2(BANKS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [LEN_W-1:0] len,
  input vaStrobe_t        st,
  input logic [CNT_W-1:0] fifoLevel
);
  logic [BANKS-1:0] useA, useB, useC, usePrev;

  assign useA = st.rdA ? (BANKS'(1) << st.addrA[BANK_W-1:0]) : '0;
  assign useB = st.rdB ? (BANKS'(1) << st.addrB[BANK_W-1:0]) : '0;
  assign useC = st.wrC ? (BANKS'(1) << st.addrC[BANK_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) usePrev <= '0;
    else       usePrev <= useA | useB | useC;
  end

  // R5: one stream per module per cycle
  a_r5_distinct_modules: assert property (@(posedge clk) disable iff (!rstN)
    ((useA & useB) | (useA & useC) | (useB & useC)) == '0);

  // R5: a module stays occupied for the cycle after an access
  a_r5_module_occupied: assert property (@(posedge clk) disable iff (!rstN)
    ((useA | useB | useC) & usePrev) == '0);

  // R3: done lasts one cycle and comes with busy low
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7: an empty run completes at once
  a_r7_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && len == '0) |=> (done && !busy));

  // R10: buffer bounded, never drained when empty
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= CNT_W'(RBUF_DEPTH));
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    st.wrC |-> fifoLevel != '0);
endmodule

bind vadd_bank_engine vadd_chk #(.BANKS(BANKS), .RBUF_DEPTH(RBUF_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .len(len), .st(strobe), .fifoLevel(fifoLevel)
);

// File: tb/sim_vadd_bank_engine.sv
module sim_vadd_bank_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  baseA = '0, baseB = '0, baseC = '0;
  logic [8:0]  len = '0;
  logic        busy, done;
  logic [15:0] cycles;
  logic        hostEn = 1'b0, hostWe = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int model [256];

  always #10 clk = ~clk;

  vadd_bank_engine u0 (
    .clk(clk), .rstN(rstN), .start(start), .baseA(baseA), .baseB(baseB),
    .baseC(baseC), .len(len), .busy(busy), .done(done), .cycles(cycles),
    .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input int addr, input int data);
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b1; hostAddr = addr[7:0]; hostWdata = data[15:0];
    @(negedge clk);
    hostEn = 1'b0; hostWe = 1'b0;
  endtask

  task automatic hostRead(input int addr, output int data);
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b0; hostAddr = addr[7:0];
    @(negedge clk);
    hostEn = 1'b0;
    data = int'(hostRdata);
  endtask

  task automatic verifyMemory(input string tag);
    int got;
    for (int a = 0; a < 256; a++) begin
      hostRead(a, got);
      check(got == model[a], tag, got, model[a]);
    end
  endtask

  // expK: negedge index of done after the start edge; -1 for colliding layouts.
  task automatic runJob(input int a, input int b, input int c, input int n,
                        input int expK, input bit disturb);
    int k;
    @(negedge clk);
    start = 1'b1; baseA = a[7:0]; baseB = b[7:0]; baseC = c[7:0]; len = n[8:0];
    @(negedge clk);
    start = 1'b0;
    k = 1;
    forever begin
      if (expK >= 0) begin
        check(busy == (k < expK), "R3 busy window", busy, k < expK);
        check(done == (k == expK), "R4 done cycle", done, k == expK);
      end else if (!done) begin
        check(busy == 1'b1, "R3 busy during run", busy, 1);
      end
      if (disturb) begin
        if (k == 3) begin
          start = 1'b1; baseA = 8'h00; baseB = 8'h00; baseC = 8'hE0; len = 9'd5;
        end
        if (k == 4) begin
          start = 1'b0;
          hostEn = 1'b1; hostWe = 1'b1; hostAddr = 8'hF0; hostWdata = 16'hDEAD;
        end
        if (k == 5) begin
          hostEn = 1'b0; hostWe = 1'b0;
        end
      end
      if (done) break;
      if (k > 3000) begin
        check(1'b0, "R3 done never seen", k, n + 9);
        break;
      end
      @(negedge clk);
      k++;
    end
    check(!busy, "R3 busy low with done", busy, 0);
    check(int'(cycles) == k - 1, "R4 cycle counter", cycles, k - 1);
    if (expK < 0)
      check(k - 1 > n + 8, "R5 R6 R10 collisions slow the run", k - 1, n + 9);
    for (int i = 0; i < n; i++)
      model[(c + i) % 256] = (model[(a + i) % 256] + model[(b + i) % 256]) & 16'hFFFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9 busy after reset", busy, 0);
    check(done == 1'b0, "R9 done after reset", done, 0);
    check(cycles == 16'd0, "R9 cycles after reset", cycles, 0);
    rstN = 1'b1;

    // R8: fill through the host port
    for (int i = 0; i < 256; i++) model[i] = (i * 16'h9E37 + 16'h1234) & 16'hFFFF;
    model[8'h00] = 16'hFFFF;
    model[8'h42] = 16'h0003;
    for (int i = 0; i < 256; i++) hostWrite(i, model[i]);
    verifyMemory("R8 host readback");

    // R4 R2 R8: spread layout with a start and a host write injected mid-run
    runJob(8'h00, 8'h42, 8'h83, 16, 16 + 9, 1'b1);
    verifyMemory("R1 R2 R8 spread run");

    // R4: single element
    runJob(8'h10, 8'h2C, 8'h95, 1, 1 + 9, 1'b0);
    verifyMemory("R1 single element");

    // R6: every stream on module 0
    runJob(8'h20, 8'h28, 8'h30, 12, -1, 1'b0);
    verifyMemory("R1 R6 colliding run");

    // R7: empty run
    runJob(8'h40, 8'h50, 8'h60, 0, 1, 1'b0);
    verifyMemory("R7 empty run leaves memory");

    // R1 R4: long spread run wrapping around the address space
    runJob(8'hF0, 8'h62, 8'hB3, 40, 40 + 9, 1'b0);
    verifyMemory("R1 wrapped run");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule